// File: doc/BRIEF.md
# Mixed-Length Instruction Aligner and Field Decoder

This block sits between an instruction fetch stream and the execution logic. Each cycle it receives the 32-bit word that holds the current halfword position, the following 32-bit word, and the halfword address of that position. It extracts one instruction from them. The instruction is either a 16-bit short form, or a 32-bit long form that adds a 16-bit immediate. The block then presents the instruction's fields on registered outputs one clock later.

There is no mode state. Bit 0 of the instruction's first halfword alone selects the long form, and the long form keeps every field of the short form. Long instructions must start on an even halfword. An immediate flag found in an odd halfword is reported as a fault.

An all-zero halfword in an odd position is alignment padding. The block skips it and decodes the instruction at the start of the following word in the same cycle, so padding costs no extra cycle. The block also reports whether the instruction was long, whether padding was skipped, and the halfword position where fetching continues.

Top module: `yx_insn_aligner`

## Requirements
- R1: The first halfword of an instruction is split as follows: the immediate flag is bit 0, the opcode is bits 7:1, register field A is bits 11:8 and register field B is bits 15:12. The group output is opcode bits 6:3, which equals halfword bits 7:4. Within a fetch word, bits 15:0 are the even halfword and bits 31:16 are the odd halfword.
- R2: At an even position with the immediate flag clear, the lower halfword of the current word is decoded as a short instruction. The immediate output is 0, the long flag is 0, and the next position is the position plus 1.
- R3: At an even position with the immediate flag set, the lower halfword is decoded as a long instruction. The immediate output equals the upper halfword of the current word, the long flag is 1, and the next position is the position plus 2.
- R4: At an odd position where the upper halfword of the current word is nonzero and has its immediate flag clear, that halfword is decoded as a short instruction. The next position is the position plus 1.
- R5: At an odd position where the upper halfword of the current word has its immediate flag set, the fault flag is 1 and the fields of that halfword are output. The long flag is 0, the skip flag is 0, the immediate output is 0, and the next position equals the input position.
- R6: At an odd position where the upper halfword of the current word is all zero, the skip flag is 1. The lower halfword of the following word is then decoded under the rules of R2 and R3, taking its immediate from the upper halfword of the following word. The next position is the position plus 2 for a short result and plus 3 for a long result.
- R7: An all-zero halfword at an even position is decoded as an ordinary short instruction with opcode 0. It is not skipped.
- R8: The outputs update on the first rising clock edge at which in_valid is 1, and they reflect the inputs sampled at that edge. When in_valid is 0 at an edge, out_valid goes to 0 and every other output holds its value.
- R9: While rst_n is low, out_valid and every field output are 0.
- R10: The next position is computed modulo 2^POS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry a position to decode this cycle |
| in_pos | input | POS_W | Halfword address of the current position |
| in_word_cur | input | 32 | Fetch word containing the current position |
| in_word_nxt | input | 32 | Fetch word that follows it |
| out_valid | output | 1 | Registered outputs hold a new decode |
| out_imm_flag | output | 1 | Immediate flag of the decoded halfword |
| out_opcode | output | 7 | Opcode |
| out_group | output | 4 | Opcode group index |
| out_reg_a | output | 4 | Register field A |
| out_reg_b | output | 4 | Register field B |
| out_imm | output | 16 | Immediate operand, 0 for short forms |
| out_long | output | 1 | The instruction is the 32-bit form |
| out_skipped | output | 1 | A padding halfword was skipped |
| out_fault | output | 1 | Immediate flag found at an odd position |
| out_next_pos | output | POS_W | Halfword address where fetching continues |

## Verification
The bench sweeps every value of the low byte of a halfword, combined with varied upper bytes. This separates the immediate flag from the opcode and group bits. Each value is placed at an even position, at an odd position, and behind odd-position padding. These three placements tell apart the lower-half, upper-half and following-word selection paths, and the short and long lengths they produce. Random words then reach the fault case and the even-position zero case. Vectors at the top of the address range show that the next position wraps, and an idle cycle shows that the outputs hold when nothing is presented.

// File: rtl/yx_dec_pkg.sv
package yx_dec_pkg;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int OPC_W   = 7;
  localparam int GRP_W   = 4;
  localparam int REG_W   = 4;
  localparam int FIELD_W = 1 + OPC_W + GRP_W + 2 * REG_W;

  typedef struct packed {
    logic             imm_flag;
    logic [OPC_W-1:0] opcode;
    logic [GRP_W-1:0] group;
    logic [REG_W-1:0] reg_a;
    logic [REG_W-1:0] reg_b;
  } yx_fields_t;
endpackage

// File: rtl/yx_field_split.sv
module yx_field_split
  import yx_dec_pkg::*;
(
  input  logic [HALF_W-1:0] half,
  output yx_fields_t        fields
);
  always_comb begin
    fields.imm_flag = half[0];
    fields.opcode   = half[7:1];
    // group is the top part of the opcode: 16 groups of 8
    fields.group    = half[7:1] >> (OPC_W - GRP_W);
    fields.reg_a    = half[11:8];
    fields.reg_b    = half[15:12];
  end
endmodule

// File: rtl/yx_align_sel.sv
module yx_align_sel
  import yx_dec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] word_cur,
  input  logic [WORD_W-1:0] word_nxt,
  output logic [HALF_W-1:0] sel_half,
  output logic [HALF_W-1:0] imm_half,
  output logic              is_long,
  output logic              skip,
  output logic              fault,
  output logic [POS_W-1:0]  next_pos
);
  logic [HALF_W-1:0] lo_cur, hi_cur, lo_nxt, hi_nxt;
  logic [1:0]        advance;

  assign lo_cur = word_cur[HALF_W-1:0];
  assign hi_cur = word_cur[WORD_W-1:HALF_W];
  assign lo_nxt = word_nxt[HALF_W-1:0];
  assign hi_nxt = word_nxt[WORD_W-1:HALF_W];

  always_comb begin
    sel_half = lo_cur;
    imm_half = '0;
    is_long  = 1'b0;
    skip     = 1'b0;
    fault    = 1'b0;
    advance  = 2'd1;
    if (!pos[0]) begin
      sel_half = lo_cur;
      is_long  = lo_cur[0];
      imm_half = lo_cur[0] ? hi_cur : '0;
      advance  = lo_cur[0] ? 2'd2 : 2'd1;
    end else if (hi_cur == '0) begin
      // padding in the odd slot: decode the next word's even slot now
      skip     = 1'b1;
      sel_half = lo_nxt;
      is_long  = lo_nxt[0];
      imm_half = lo_nxt[0] ? hi_nxt : '0;
      advance  = lo_nxt[0] ? 2'd3 : 2'd2;
    end else if (hi_cur[0]) begin
      fault    = 1'b1;
      sel_half = hi_cur;
      advance  = 2'd0;
    end else begin
      sel_half = hi_cur;
    end
  end

  assign next_pos = pos + POS_W'(advance);
endmodule

// File: rtl/yx_insn_aligner.sv
module yx_insn_aligner
  import yx_dec_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [POS_W-1:0]   in_pos,
  input  logic [WORD_W-1:0]  in_word_cur,
  input  logic [WORD_W-1:0]  in_word_nxt,
  output logic               out_valid,
  output logic               out_imm_flag,
  output logic [OPC_W-1:0]   out_opcode,
  output logic [GRP_W-1:0]   out_group,
  output logic [REG_W-1:0]   out_reg_a,
  output logic [REG_W-1:0]   out_reg_b,
  output logic [HALF_W-1:0]  out_imm,
  output logic               out_long,
  output logic               out_skipped,
  output logic               out_fault,
  output logic [POS_W-1:0]   out_next_pos
);
  logic [HALF_W-1:0] sel_half, imm_half;
  logic              sel_long, sel_skip, sel_fault;
  logic [POS_W-1:0]  sel_next;
  yx_fields_t        sel_fields;

  yx_align_sel #(.POS_W(POS_W)) u_sel (
    .pos      (in_pos),
    .word_cur (in_word_cur),
    .word_nxt (in_word_nxt),
    .sel_half (sel_half),
    .imm_half (imm_half),
    .is_long  (sel_long),
    .skip     (sel_skip),
    .fault    (sel_fault),
    .next_pos (sel_next)
  );

  yx_field_split u_split (
    .half   (sel_half),
    .fields (sel_fields)
  );

  // next-state
  yx_fields_t        fields_q, fields_d;
  logic [HALF_W-1:0] imm_q, imm_d;
  logic              long_q, long_d, skip_q, skip_d, fault_q, fault_d;
  logic [POS_W-1:0]  next_q, next_d;
  logic              valid_d, load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d  = in_valid;
    fields_d = load_en ? sel_fields : fields_q;
    imm_d    = load_en ? imm_half   : imm_q;
    long_d   = load_en ? sel_long   : long_q;
    skip_d   = load_en ? sel_skip   : skip_q;
    fault_d  = load_en ? sel_fault  : fault_q;
    next_d   = load_en ? sel_next   : next_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fields_q  <= '0;
      imm_q     <= '0;
      long_q    <= 1'b0;
      skip_q    <= 1'b0;
      fault_q   <= 1'b0;
      next_q    <= '0;
    end else begin
      out_valid <= valid_d;
      fields_q  <= fields_d;
      imm_q     <= imm_d;
      long_q    <= long_d;
      skip_q    <= skip_d;
      fault_q   <= fault_d;
      next_q    <= next_d;
    end
  end

  assign out_imm_flag = fields_q.imm_flag;
  assign out_opcode   = fields_q.opcode;
  assign out_group    = fields_q.group;
  assign out_reg_a    = fields_q.reg_a;
  assign out_reg_b    = fields_q.reg_b;
  assign out_imm      = imm_q;
  assign out_long     = long_q;
  assign out_skipped  = skip_q;
  assign out_fault    = fault_q;
  assign out_next_pos = next_q;

  // R3 R6: a long instruction always leaves fetch on an even halfword
  a_r3_long_ends_even: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_long |-> !out_next_pos[0]);

  // R5: a fault is never long and never a skip
  a_r5_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_long && !out_skipped && out_imm == '0);

  // R2: without the flag there is no immediate
  a_r2_short_no_imm: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_imm_flag |-> !out_long && out_imm == '0);

  // R1: outside a fault the flag alone picks the length
  a_r1_flag_sets_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fault |-> out_imm_flag == out_long);

  // R8: valid follows the sampled input
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8: idle cycles hold the decode
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_next_pos) && $stable(out_imm));

  // R6: a skipped decode lands after the padding
  a_r6_skip_advances: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_skipped |-> !out_fault);
endmodule

// File: tb/yx_insn_aligner_bench.sv
module yx_insn_aligner_bench;
  localparam int POS_W = 16;
  localparam int BW    = 1 + 7 + 4 + 4 + 4 + 16 + 1 + 1 + 1 + POS_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [POS_W-1:0]  in_pos;
  logic [31:0]       in_word_cur, in_word_nxt;
  logic              out_valid, out_imm_flag, out_long, out_skipped, out_fault;
  logic [6:0]        out_opcode;
  logic [3:0]        out_group, out_reg_a, out_reg_b;
  logic [15:0]       out_imm;
  logic [POS_W-1:0]  out_next_pos;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  yx_insn_aligner #(.POS_W(POS_W)) u_yx_insn_aligner (
    .clk, .rst_n, .in_valid, .in_pos, .in_word_cur, .in_word_nxt,
    .out_valid, .out_imm_flag, .out_opcode, .out_group, .out_reg_a,
    .out_reg_b, .out_imm, .out_long, .out_skipped, .out_fault, .out_next_pos
  );

  function automatic logic [BW-1:0] actual();
    return {out_imm_flag, out_opcode, out_group, out_reg_a, out_reg_b,
            out_imm, out_long, out_skipped, out_fault, out_next_pos};
  endfunction

  // expected bundle built from the requirements
  function automatic logic [BW-1:0] model(input logic [POS_W-1:0] p,
                                          input logic [31:0] c,
                                          input logic [31:0] n,
                                          output string tag);
    logic [15:0] h, im;
    logic lg, sk, ft;
    int adv;
    im = 16'h0; lg = 0; sk = 0; ft = 0;
    if (p % 2 == 0) begin
      h = c[15:0];
      lg = h[0];
      im = lg ? c[31:16] : 16'h0;
      adv = lg ? 2 : 1;
      tag = (h == 16'h0) ? "R1,R7" : (lg ? "R1,R3" : "R1,R2");
    end else if (c[31:16] == 16'h0) begin
      h = n[15:0];
      sk = 1;
      lg = h[0];
      im = lg ? n[31:16] : 16'h0;
      adv = lg ? 3 : 2;
      tag = "R1,R6";
    end else if (c[16]) begin
      h = c[31:16];
      ft = 1;
      adv = 0;
      tag = "R1,R5";
    end else begin
      h = c[31:16];
      adv = 1;
      tag = "R1,R4";
    end
    if (int'(p) + adv >= (1 << POS_W)) tag = {tag, ",R10"};
    return {h[0], h[7:1], 4'((h >> 4) & 16'hF), h[11:8], h[15:12], im,
            lg, sk, ft, POS_W'((int'(p) + adv) % (1 << POS_W))};
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [POS_W-1:0] p, input logic [31:0] c,
                         input logic [31:0] n);
    string tag;
    logic [BW-1:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_pos = p; in_word_cur = c; in_word_nxt = n;
    e = model(p, c, n, tag);
    @(posedge clk); #1;
    check({tag, ",R8 valid"}, {{(BW-1){1'b0}}, out_valid}, {{(BW-1){1'b0}}, 1'b1});
    check(tag, actual(), e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] held;
    rst_n = 1'b0; in_valid = 1'b0; in_pos = '0; in_word_cur = '0; in_word_nxt = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {actual(), out_valid}, '0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 256; i++) begin
      logic [15:0] h;
      logic [15:0] q;
      h = {8'((i * 37 + 11) & 255), 8'(i)};
      q = 16'((i * 91 + 5) & 16'hFFFF);
      run_vec(16'(2 * i), {q, h}, {q ^ 16'h5A5A, ~h});
      run_vec(16'(2 * i + 1), {h, q}, {~q, h ^ 16'h00FE});
      run_vec(16'(2 * i + 301), {16'h0, q}, {q, h});
    end

    // even-position zero and zero after padding
    run_vec(16'h0040, 32'h1234_0000, 32'h0);
    run_vec(16'h0041, 32'h0000_FFFF, 32'h0000_0000);

    for (int k = 0; k < 1500; k++) begin
      logic [31:0] c, n;
      c = $urandom;
      n = $urandom;
      if (k % 5 == 0) c[31:16] = 16'h0;
      if (k % 7 == 0) c[15:0]  = 16'h0;
      run_vec(16'($urandom), c, n);
    end

    // R10 wrap at the top of the address range
    run_vec(16'hFFFE, 32'hBEEF_0F01, 32'h0);
    run_vec(16'hFFFF, 32'h0000_1111, 32'hCAFE_2203);
    run_vec(16'hFFFF, 32'hA2B4_0000, 32'h0);
    run_vec(16'hFFFE, 32'h0000_3370, 32'h0);

    // R8 idle cycle: valid drops, everything else holds
    held = actual();
    @(negedge clk);
    in_valid = 1'b0; in_pos = 16'h1357; in_word_cur = 32'h0101_0101; in_word_nxt = '1;
    @(posedge clk); #1;
    check("R8 idle valid", {{(BW-1){1'b0}}, out_valid}, '0);
    check("R8 idle hold", actual(), held);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule